// File: doc/BRIEF.md
# Reciprocal Square Root Estimate Unit

This unit takes one single-precision IEEE-754 word and produces a coarse approximation of 1/sqrt(x). The approximation carries about 8 significant bits. It is meant as a seed for a later Newton-style refinement step elsewhere in a datapath. An operand enters with a valid strobe, and the registered result appears exactly one clock later.

For a finite positive normal operand, the least significant bit of the biased exponent decides how the mantissa is scaled before lookup. Each scaling has its own 128-entry constant table, and the tables are built at elaboration from an exact integer rounding rule. The unit has a fixed policy for special operands: negative values, zeros, subnormals, infinities, NaNs and very large magnitudes each get a defined result.

Field positions used throughout: the sign is bit 31, the biased exponent field is bits [30:23], and the fraction is bits [22:0].

Top module: `rsqrt_est`

## Requirements
- R1: `out_valid_o` equals `in_valid_i` from the previous rising clock edge. While `rst_ni` is low, `out_valid_o` and `out_data_o` are both 0.
- R2: When `in_valid_i` is low at a clock edge, `out_data_o` keeps its previous value.
- R3: A word with sign bit 1 and a nonzero exponent field that is not a NaN gives 32'h7FC00000. This includes negative infinity.
- R4: A word with sign bit 0 and an exponent field of 253 or more that is not a NaN gives 32'h00000000. This includes positive infinity.
- R5: A word whose exponent field is 0 gives an infinity carrying the input sign: {sign, 8'hFF, 23'h0}. Subnormals count as zeros here.
- R6: A NaN (exponent field 255, fraction nonzero) is returned bit for bit, whatever its sign.
- R7: For a positive normal operand with exponent field e in 1..252, the result exponent field is floor((380 - e) / 2).
- R8: When e is odd, let q = 128 + fraction[22:16]. The estimate s is 256/sqrt((q + 0.5)/512), rounded to the nearest integer.
- R9: When e is even, with the same q, the estimate s is 256/sqrt((q + 0.5)/256), rounded to the nearest integer.
- R10: For a positive normal operand, the result sign is 0. Result bits [22:15] hold s[7:0], and bits [14:0] are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Operand strobe |
| in_data_i | input | 32 | Single-precision operand |
| out_valid_o | output | 1 | Result strobe, one cycle after the operand |
| out_data_o | output | 32 | Single-precision estimate |

## Verification
The bench targets the boundaries between operand classes:
- **Exponent 252 against 253.** A wrong large-magnitude threshold would return 0 for a value that still has a valid estimate.
- **Negative NaNs.** If the NaN test were ordered after the sign test, a negative NaN would come out as the default NaN.
- **Negative zero and negative subnormals.** Treating these as negative would replace negative infinity with NaN.
- **Both exponent parities.** Each parity is driven with index 0 and index 127. A swapped or misindexed table shows up as a wrong fraction byte, and a missing rounding step shows up as an off-by-one byte.
- **Idle cycles.** A design that updated its data register on every edge would fail the idle cycles driven between operands.

// File: rtl/rsqrt_pkg.sv
package rsqrt_pkg;
  localparam int WORD_W    = 32;
  localparam int EXP_W     = 8;
  localparam int FRAC_W    = 23;
  localparam int IDX_W     = 7;
  localparam int EST_W     = 8;
  localparam int TBL_N     = 1 << IDX_W;
  localparam int EXP_SUM   = 380;
  localparam int BIG_EXP   = 253;
  localparam int STEP_FINE = 512;
  localparam int STEP_CRS  = 256;
  localparam logic [WORD_W-1:0] QNAN_WORD = 32'h7FC0_0000;

  typedef enum logic [2:0] {
    CL_NORM,
    CL_NEG,
    CL_BIG,
    CL_ZERO,
    CL_NAN
  } op_class_e;

  // Nearest integer s to 2^EST_W / sqrt((q+0.5)/den), solved exactly:
  // largest s with (2s-1)^2 * (2q+1) <= 2^(2*EST_W+3) * den
  function automatic logic [EST_W-1:0] rsq_entry(input int idx, input int den);
    longint q, rhs, lhs;
    int best;
    q    = longint'(TBL_N + idx);
    rhs  = (longint'(1) << (2 * EST_W + 3)) * longint'(den);
    best = 1 << EST_W;
    for (int s = (1 << EST_W); s < (2 << EST_W); s++) begin
      lhs = longint'(2 * s - 1) * longint'(2 * s - 1) * (2 * q + 1);
      if (lhs <= rhs) best = s;
    end
    return best[EST_W-1:0];
  endfunction
endpackage

// File: rtl/rsqrt_classify.sv
module rsqrt_classify
  import rsqrt_pkg::*;
(
  input  logic [WORD_W-1:0] word_i,
  output op_class_e         cls_o
);
  logic              sgn;
  logic [EXP_W-1:0]  ex;
  logic [FRAC_W-1:0] fr;
  logic              is_zero, is_nan, is_big;

  assign sgn     = word_i[WORD_W-1];
  assign ex      = word_i[FRAC_W +: EXP_W];
  assign fr      = word_i[FRAC_W-1:0];
  // exponent field 0 covers subnormals: flushed to zero
  assign is_zero = (ex == '0);
  assign is_nan  = (ex == '1) && (fr != '0);
  assign is_big  = (ex >= EXP_W'(BIG_EXP)) && !is_nan;

  always_comb begin
    if (sgn && !is_zero && !is_nan) cls_o = CL_NEG;
    else if (is_big)                cls_o = CL_BIG;
    else if (is_zero)               cls_o = CL_ZERO;
    else if (is_nan)                cls_o = CL_NAN;
    else                            cls_o = CL_NORM;
  end
endmodule

// File: rtl/rsqrt_lut.sv
module rsqrt_lut
  import rsqrt_pkg::*;
#(
  parameter int STEP = 512
) (
  input  logic [IDX_W-1:0] idx_i,
  output logic [EST_W-1:0] est_o
);
  logic [EST_W-1:0] tbl [TBL_N];

  for (genvar i = 0; i < TBL_N; i++) begin : g_ent
    localparam logic [EST_W-1:0] ENT = rsq_entry(i, STEP);
    assign tbl[i] = ENT;
  end

  assign est_o = tbl[idx_i];
endmodule

// File: rtl/rsqrt_est.sv
module rsqrt_est
  import rsqrt_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  input  logic [WORD_W-1:0] in_data_i,
  output logic              out_valid_o,
  output logic [WORD_W-1:0] out_data_o
);
  localparam int DIFF_W = EXP_W + 1;

  op_class_e         cls;
  logic [EXP_W-1:0]  ex;
  logic [IDX_W-1:0]  idx;
  logic [EST_W-1:0]  est_fine, est_crs, est_sel;
  logic [DIFF_W-1:0] exp_diff;
  logic [EXP_W-1:0]  res_exp;
  logic [WORD_W-1:0] nxt_data;

  assign ex  = in_data_i[FRAC_W +: EXP_W];
  assign idx = in_data_i[FRAC_W-1 -: IDX_W];

  rsqrt_classify u_cls (
    .word_i (in_data_i),
    .cls_o  (cls)
  );

  // odd exponent: mantissa in [0.25,0.5), 1/512 steps
  rsqrt_lut #(.STEP(STEP_FINE)) u_lut_odd (
    .idx_i (idx),
    .est_o (est_fine)
  );

  // even exponent: mantissa in [0.5,1), 1/256 steps
  rsqrt_lut #(.STEP(STEP_CRS)) u_lut_even (
    .idx_i (idx),
    .est_o (est_crs)
  );

  assign est_sel  = ex[0] ? est_fine : est_crs;
  assign exp_diff = DIFF_W'(EXP_SUM) - {1'b0, ex};
  assign res_exp  = exp_diff[DIFF_W-1:1];

  always_comb begin
    unique case (cls)
      CL_NEG:  nxt_data = QNAN_WORD;
      CL_BIG:  nxt_data = '0;
      CL_ZERO: nxt_data = {in_data_i[WORD_W-1], {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
      CL_NAN:  nxt_data = in_data_i;
      default: nxt_data = {1'b0, res_exp, est_sel, {(FRAC_W-EST_W){1'b0}}};
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      out_data_o  <= '0;
    end else begin
      out_valid_o <= in_valid_i;
      if (in_valid_i) out_data_o <= nxt_data;
    end
  end
endmodule

// File: rtl/rsqrt_est_chk.sv
module rsqrt_est_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        in_valid_i,
  input logic [31:0] in_data_i,
  input logic        out_valid_o,
  input logic [31:0] out_data_o
);
  logic       sg;
  logic [7:0] ex;
  logic       nan_in;

  assign sg     = in_data_i[31];
  assign ex     = in_data_i[30:23];
  assign nan_in = (ex == 8'hFF) && (in_data_i[22:0] != '0);

  // R1
  valid_lat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> out_valid_o == $past(in_valid_i));

  // R2
  data_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> $stable(out_data_o));

  // R3
  neg_nan_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i && sg && ex != 8'h00 && !nan_in |=> out_data_o == 32'h7FC0_0000);

  // R4
  big_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i && !sg && ex >= 8'd253 && !nan_in |=> out_data_o == 32'h0);

  // R5
  zero_inf_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i && ex == 8'h00 |=> out_data_o == {$past(sg), 8'hFF, 23'h0});

  // R6
  nan_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i && nan_in |=> out_data_o == $past(in_data_i));

  // R7
  res_exp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i && !sg && ex != 8'h00 && ex < 8'd253
    |=> out_data_o[30:23] == 8'((9'd380 - {1'b0, $past(ex)}) >> 1));

  // R10
  res_shape_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i && !sg && ex != 8'h00 && ex < 8'd253
    |=> !out_data_o[31] && out_data_o[14:0] == 15'h0);
endmodule

bind rsqrt_est rsqrt_est_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .in_valid_i  (in_valid_i),
  .in_data_i   (in_data_i),
  .out_valid_o (out_valid_o),
  .out_data_o  (out_data_o)
);

// File: tb/rsqrt_est_tb.sv
module rsqrt_est_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        in_valid_i = 1'b0;
  logic [31:0] in_data_i = '0;
  logic        out_valid_o;
  logic [31:0] out_data_o;
  int          n_chk = 0;
  int          n_err = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  rsqrt_est u_dut (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .in_valid_i  (in_valid_i),
    .in_data_i   (in_data_i),
    .out_valid_o (out_valid_o),
    .out_data_o  (out_data_o)
  );

  function automatic logic [31:0] model(input logic [31:0] a);
    logic [7:0] e;
    int q, s;
    real den;
    e = a[30:23];
    if (e == 8'hFF && a[22:0] != 0) return a;
    if (e == 8'h00) return {a[31], 8'hFF, 23'h0};
    if (a[31]) return 32'h7FC0_0000;
    if (e >= 8'd253) return 32'h0;
    q   = 128 + int'(a[22:16]);
    den = e[0] ? 512.0 : 256.0;
    s   = $rtoi(256.0 / $sqrt((real'(q) + 0.5) / den) + 0.5);
    return {1'b0, 8'((380 - int'(e)) / 2), s[7:0], 15'h0};
  endfunction

  function automatic string tag_of(input logic [31:0] a);
    logic [7:0] e;
    e = a[30:23];
    if (e == 8'hFF && a[22:0] != 0) return "R6";
    if (e == 8'h00) return "R5";
    if (a[31]) return "R3";
    if (e >= 8'd253) return "R4";
    return e[0] ? "R8/R7/R10" : "R9/R7/R10";
  endfunction

  task automatic chk(input logic ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic apply(input logic v, input logic [31:0] a);
    logic [31:0] prev;
    prev = out_data_o;
    @(negedge clk);
    in_valid_i = v;
    in_data_i  = a;
    @(negedge clk);
    chk(out_valid_o == v, "R1", 32'(out_valid_o), 32'(v));
    if (v) chk(out_data_o == model(a), tag_of(a), out_data_o, model(a));
    else   chk(out_data_o == prev, "R2", out_data_o, prev);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] w;
    void'($urandom(32'd20240611));
    // reset state (R1)
    in_valid_i = 1'b1;
    in_data_i  = 32'h3F80_0000;
    repeat (3) @(negedge clk);
    chk(out_valid_o == 1'b0 && out_data_o == 32'h0, "R1", out_data_o, 32'h0);
    in_valid_i = 1'b0;
    rst_ni = 1'b1;

    apply(1'b1, 32'h3F80_0000);  // 1.0, odd exponent, index 0 (R8)
    apply(1'b1, 32'h4000_0000);  // 2.0, even exponent, index 0 (R9)
    apply(1'b1, 32'h40FF_0000);  // odd, index 127 (R8)
    apply(1'b1, 32'h407F_0000);  // even, index 127 (R9)
    apply(1'b1, 32'h0080_0000);  // smallest normal, e=1 (R7)
    apply(1'b1, 32'h7E7F_FFFF);  // e=252 still normal (R7)
    apply(1'b1, 32'h7E80_0000);  // e=253 large (R4)
    apply(1'b1, 32'h7F80_0000);  // +inf (R4)
    apply(1'b1, 32'hFF80_0000);  // -inf (R3)
    apply(1'b1, 32'hBF80_0000);  // -1.0 (R3)
    apply(1'b1, 32'h0000_0000);  // +0 (R5)
    apply(1'b1, 32'h8000_0000);  // -0 (R5)
    apply(1'b1, 32'h8000_0123);  // negative subnormal flushed (R5)
    apply(1'b1, 32'h0012_3456);  // positive subnormal flushed (R5)
    apply(1'b1, 32'hFFC0_0001);  // negative NaN passes (R6)
    apply(1'b1, 32'h7F80_0001);  // signalling NaN passes (R6)
    apply(1'b0, 32'h1234_5678);  // idle with new data (R2)
    apply(1'b0, 32'hFFFF_FFFF);  // idle again (R2)

    for (int i = 0; i < 3000; i++) begin
      w = $urandom;
      if ($urandom % 4 < 2) begin
        w[31]    = 1'b0;
        w[30:23] = 8'(1 + $urandom % 252);
      end
      apply(($urandom % 5) != 0, w);
    end

    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule